// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and a cartridge's external ROM and battery RAM. The processor can only see a 32 KiB ROM window and an 8 KiB RAM window. The controller makes larger memories reachable by paging them into those windows.

The ROM window has two halves. The lower 16 KiB always shows the first ROM page. The upper 16 KiB shows a page that software selects. The ROM itself cannot be written, so processor writes into the ROM window are used as control updates instead. Those writes set four things:

- whether external RAM accepts writes,
- which ROM page is mapped into the upper window,
- which RAM page is mapped into the RAM window,
- a banking-mode bit.

Address translation is purely combinational, and read data from ROM or RAM is steered back onto the processor read bus. An access that falls on no memory returns the idle-bus value 0xFF.

Parameters set the number of ROM pages (2 to 32), the number of RAM pages (1 to 4), and whether RAM is fitted at all. A requested ROM page beyond the fitted count is limited to the highest page that exists.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM page is 1, the RAM page is 0, RAM writes are disabled and `adv_mode` is 0.
- R2: For CPU addresses 0x0000–0x3FFF, `rom_addr` equals the CPU address and `cpu_rdata` returns `rom_rdata`.
- R3: A write to 0x2000–0x3FFF loads data bits 4:0 as the ROM page; data bits 7:5 are ignored. For CPU addresses 0x4000–0x7FFF, `rom_addr` = page × 0x4000 + CPU address bits 13:0, and `cpu_rdata` returns `rom_rdata`.
- R4: A ROM page request of 0 (data bits 4:0 all zero) selects page 1.
- R5: A ROM page request above ROM_BANKS−1 selects page ROM_BANKS−1.
- R6: A write to 0x0000–0x1FFF enables RAM writes when data bits 3:0 equal 0xA. Any other value disables them.
- R7: A write to 0x4000–0x5FFF loads data bits 1:0 as the RAM page. For CPU addresses 0xA000–0xBFFF, `ram_addr` = RAM page × 0x2000 + (CPU address − 0xA000), and reads return `ram_rdata`.
- R8: `ram_we` is asserted only for a CPU write to 0xA000–0xBFFF while RAM writes are enabled. `ram_wdata` then carries the CPU data.
- R9: When the RAM page is not below RAM_BANKS, reads of 0xA000–0xBFFF return 0xFF and writes there do not assert `ram_we`.
- R10: A write to 0x6000–0x7FFF sets `adv_mode` to data bit 0.
- R11: Reads of 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF.
- R12: With RAM_PRESENT = 0, enable writes have no effect: `ram_we` stays low and reads of 0xA000–0xBFFF return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe; registers update at the clock edge |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_addr | output | 14+clog2(ROM_BANKS) | Physical ROM address |
| rom_rdata | input | 8 | ROM data at `rom_addr` |
| ram_addr | output | 13+clog2(RAM_BANKS) | Physical RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM data at `ram_addr` |
| adv_mode | output | 1 | Stored banking-mode bit |

## Verification
The ROM page register is swept over every 6-bit write value on a six-page configuration. This separates three cases: the zero-to-one substitution, the limit to the top page for a count that is not a power of two, and masking of the upper data bits. Each value is read at the bottom, middle and top of the upper window.

The RAM enable is swept over all 256 data values, so that only a low nibble of 0xA opens the write strobe. RAM pages are written and read back to show that pages are kept apart and that nonexistent pages stay silent. A second instance without RAM confirms that enables are ignored there.

// File: rtl/cart_pkg.sv
package cart_pkg;

   localparam logic [7:0] IDLE_BUS = 8'hFF;

   typedef enum logic [1:0] {
      RG_ROM_FIXED,
      RG_ROM_PAGED,
      RG_XRAM,
      RG_NONE
   } region_e;

   typedef enum logic [1:0] {
      CR_WR_GATE,
      CR_ROM_PAGE,
      CR_RAM_PAGE,
      CR_MODE
   } ctrl_e;

   function automatic region_e region_of(input logic [15:0] a);
      if (a[15:14] == 2'b00)       return RG_ROM_FIXED;
      else if (a[15:14] == 2'b01)  return RG_ROM_PAGED;
      else if (a[15:13] == 3'b101) return RG_XRAM;
      else                         return RG_NONE;
   endfunction

endpackage

// File: rtl/cart_regs.sv
module cart_regs #(
   parameter int ROM_BANKS   = 32,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [15:0] addr,
   input  logic [7:0] wdata,
   output logic [4:0] rom_page,
   output logic [1:0] ram_page,
   output logic       ram_en,
   output logic       adv_mode
);
   import cart_pkg::*;

   localparam logic [4:0] TOP_PAGE = 5'(ROM_BANKS - 1);

   logic  ctl_wr;
   ctrl_e sel;
   logic  unused_hi;

   assign ctl_wr    = wr && (addr[15] == 1'b0);
   assign sel       = ctrl_e'(addr[14:13]);
   assign unused_hi = ^{wdata[7:5], addr[12:0]};

   function automatic logic [4:0] pick_page(input logic [4:0] req);
      logic [4:0] p;
      p = (req == 5'd0) ? 5'd1 : req;
      if (p > TOP_PAGE) p = TOP_PAGE;
      return p;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rom_page <= 5'd1;
         ram_page <= 2'd0;
         adv_mode <= 1'b0;
      end else if (ctl_wr) begin
         case (sel)
            CR_ROM_PAGE: rom_page <= pick_page(wdata[4:0]);
            CR_RAM_PAGE: ram_page <= wdata[1:0];
            CR_MODE:     adv_mode <= wdata[0];
            default:     ;
         endcase
      end
   end

   generate
      if (RAM_PRESENT) begin : g_gate
         logic gate_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               gate_q <= 1'b0;
            else if (ctl_wr && sel == CR_WR_GATE)
               gate_q <= (wdata[3:0] == 4'hA);
         end
         assign ram_en = gate_q;
      end else begin : g_nogate
         assign ram_en = 1'b0;
      end
   endgenerate

   assert_page_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rom_page != 5'd0);

   assert_page_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rom_page <= TOP_PAGE);

   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> ($stable(rom_page) && $stable(ram_page) && $stable(adv_mode) && $stable(ram_en)));

   assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && sel == CR_MODE) |=> (adv_mode == $past(wdata[0])));

endmodule

// File: rtl/cart_xlate.sv
module cart_xlate #(
   parameter int ROM_BANKS   = 32,
   parameter int RAM_BANKS   = 4,
   parameter bit RAM_PRESENT = 1'b1,
   localparam int BANK_W     = $clog2(ROM_BANKS),
   localparam int RAM_BW     = $clog2(RAM_BANKS),
   localparam int ROM_AW     = 14 + BANK_W,
   localparam int RAM_AW     = 13 + RAM_BW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_wr,
   input  logic [4:0]        rom_page,
   input  logic [1:0]        ram_page,
   input  logic              ram_en,
   input  logic [7:0]        rom_rdata,
   input  logic [7:0]        ram_rdata,
   output logic [ROM_AW-1:0] rom_addr,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   output logic [7:0]        cpu_rdata
);
   import cart_pkg::*;

   region_e rg;
   logic    page_ok;
   logic    ram_live;

   assign rg      = region_of(cpu_addr);
   assign page_ok = (int'(ram_page) < RAM_BANKS);

   generate
      if (RAM_PRESENT) begin : g_live
         assign ram_live = page_ok;
      end else begin : g_dead
         assign ram_live = 1'b0;
      end

      if (RAM_BW == 0) begin : g_one_page
         logic unused_pg;
         assign unused_pg = ^ram_page;
         assign ram_addr  = cpu_addr[12:0];
      end else begin : g_multi_page
         assign ram_addr = {ram_page[RAM_BW-1:0], cpu_addr[12:0]};
      end

      if (BANK_W < 5) begin : g_narrow
         logic unused_rp;
         assign unused_rp = ^rom_page[4:BANK_W];
      end
   endgenerate

   always_comb begin
      rom_addr = ROM_AW'(cpu_addr[13:0]);
      if (rg == RG_ROM_PAGED)
         rom_addr = {rom_page[BANK_W-1:0], cpu_addr[13:0]};
   end

   assign ram_we = cpu_wr && (rg == RG_XRAM) && ram_live && ram_en;

   always_comb begin
      case (rg)
         RG_ROM_FIXED, RG_ROM_PAGED: cpu_rdata = rom_rdata;
         RG_XRAM:                    cpu_rdata = ram_live ? ram_rdata : IDLE_BUS;
         default:                    cpu_rdata = IDLE_BUS;
      endcase
   end

   assert_we_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_en && cpu_wr));

   assert_missing_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b101 && !page_ok) |-> (cpu_rdata == 8'hFF && !ram_we));

   assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11) |-> cpu_rdata == 8'hFF);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl #(
   parameter int ROM_BANKS   = 32,
   parameter int RAM_BANKS   = 4,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [15:0]                   cpu_addr,
   input  logic [7:0]                    cpu_wdata,
   input  logic                          cpu_wr,
   output logic [7:0]                    cpu_rdata,
   output logic [13+$clog2(ROM_BANKS):0] rom_addr,
   input  logic [7:0]                    rom_rdata,
   output logic [12+$clog2(RAM_BANKS):0] ram_addr,
   output logic [7:0]                    ram_wdata,
   output logic                          ram_we,
   input  logic [7:0]                    ram_rdata,
   output logic                          adv_mode
);

   generate
      if (ROM_BANKS < 2 || ROM_BANKS > 32) begin : g_bad_rom
         $error("ROM_BANKS must lie in 2..32");
      end
      if (RAM_BANKS < 1 || RAM_BANKS > 4) begin : g_bad_ram
         $error("RAM_BANKS must lie in 1..4");
      end
   endgenerate

   logic [4:0] rom_page;
   logic [1:0] ram_page;
   logic       ram_en;

   cart_regs #(
      .ROM_BANKS  (ROM_BANKS),
      .RAM_PRESENT(RAM_PRESENT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cpu_wr),
      .addr    (cpu_addr),
      .wdata   (cpu_wdata),
      .rom_page(rom_page),
      .ram_page(ram_page),
      .ram_en  (ram_en),
      .adv_mode(adv_mode)
   );

   cart_xlate #(
      .ROM_BANKS  (ROM_BANKS),
      .RAM_BANKS  (RAM_BANKS),
      .RAM_PRESENT(RAM_PRESENT)
   ) u_xlate (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_addr (cpu_addr),
      .cpu_wr   (cpu_wr),
      .rom_page (rom_page),
      .ram_page (ram_page),
      .ram_en   (ram_en),
      .rom_rdata(rom_rdata),
      .ram_rdata(ram_rdata),
      .rom_addr (rom_addr),
      .ram_addr (ram_addr),
      .ram_we   (ram_we),
      .cpu_rdata(cpu_rdata)
   );

   assign ram_wdata = cpu_wdata;

endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

   localparam int NB = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_wdata = 8'h00;
   logic        cpu_wr = 1'b0;

   logic [7:0]  cpu_rdata, rom_rdata, ram_wdata, ram_rdata;
   logic [16:0] rom_addr;
   logic [13:0] ram_addr;
   logic        ram_we, adv_mode;

   logic [7:0]  nr_rdata, nr_rom_rdata, nr_ram_wdata;
   logic [14:0] nr_rom_addr;
   logic [12:0] nr_ram_addr;
   logic        nr_ram_we, nr_adv;

   logic [7:0] mem [0:255];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   function automatic logic [7:0] rom_byte(input int pa);
      return 8'((pa & 255) ^ ((pa >> 14) * 37));
   endfunction

   assign rom_rdata    = rom_byte(int'(rom_addr));
   assign nr_rom_rdata = rom_byte(int'(nr_rom_addr));
   assign ram_rdata    = mem[{ram_addr[13], ram_addr[6:0]}];

   always @(posedge clk) if (ram_we) mem[{ram_addr[13], ram_addr[6:0]}] <= ram_wdata;

   cart_bank_ctrl #(.ROM_BANKS(NB), .RAM_BANKS(2), .RAM_PRESENT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
      .rom_rdata(rom_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_we(ram_we), .ram_rdata(ram_rdata), .adv_mode(adv_mode));

   cart_bank_ctrl #(.ROM_BANKS(2), .RAM_BANKS(1), .RAM_PRESENT(1'b0)) u_dut_nr (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rdata(nr_rdata), .rom_addr(nr_rom_addr),
      .rom_rdata(nr_rom_rdata), .ram_addr(nr_ram_addr), .ram_wdata(nr_ram_wdata),
      .ram_we(nr_ram_we), .ram_rdata(8'h5A), .adv_mode(nr_adv));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic look(input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; cpu_wr = 1'b0;
      #1;
   endtask

   task automatic probe_we(input logic [15:0] a, input logic [7:0] d, output bit we, output bit we_nr);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      #1;
      we = ram_we; we_nr = nr_ram_we;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      bit we, wn;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      look(16'h4000);
      chk(rom_addr == 17'h04000, "R1 rom page", rom_addr, 17'h04000);
      chk(adv_mode == 1'b0, "R1 mode", adv_mode, 0);
      look(16'hA123);
      chk(ram_addr == 14'h0123, "R1 ram page", ram_addr, 14'h0123);
      probe_we(16'hA001, 8'h11, we, wn);
      chk(we == 1'b0, "R1 ram disabled", we, 0);

      // R2: fixed window sweep
      wr(16'h2000, 8'h03);
      for (int a = 0; a < 16'h4000; a += 16'h03F1) begin
         look(16'(a));
         chk(rom_addr == 17'(a), "R2 rom_addr", rom_addr, a);
         chk(cpu_rdata == rom_byte(a), "R2 rdata", cpu_rdata, rom_byte(a));
      end

      // R3 R4 R5: page sweep
      for (int d = 0; d < 64; d++) begin
         int eb;
         string tag;
         eb = d & 31;
         if (eb == 0) begin eb = 1; tag = "R4"; end
         else if (eb > NB - 1) begin eb = NB - 1; tag = "R5"; end
         else tag = "R3";
         wr(16'(16'h2000 + (d * 16'h0101 & 16'h1FFF)), 8'(d | (d << 5)));
         for (int k = 0; k < 3; k++) begin
            int off, pa;
            off = (k == 0) ? 0 : (k == 1) ? 16'h1234 : 16'h3FFF;
            pa  = eb * 16'h4000 + off;
            look(16'(16'h4000 + off));
            chk(rom_addr == 17'(pa), tag, rom_addr, pa);
            chk(cpu_rdata == rom_byte(pa), tag, cpu_rdata, rom_byte(pa));
         end
      end

      // R6 R12: enable nibble sweep
      wr(16'h4000, 8'h00);
      for (int d = 0; d < 256; d++) begin
         wr(16'(16'h0000 + ((d * 16'h0023) & 16'h1FFF)), 8'(d));
         probe_we(16'(16'hA000 + (d & 16'h3F)), 8'(d), we, wn);
         chk(we == ((d & 15) == 10), "R6 enable", we, (d & 15) == 10);
         chk(wn == 1'b0, "R12 no-ram enable", wn, 0);
      end

      // R7 R8: page separation and write back
      wr(16'h1FFF, 8'h0A);
      wr(16'h4000, 8'hFC);
      probe_we(16'hA005, 8'h5A, we, wn);
      chk(we == 1'b1, "R8 enabled write", we, 1);
      wr(16'h5FFF, 8'h05);
      look(16'hBF45);
      chk(ram_addr == 14'h3F45, "R7 ram_addr", ram_addr, 14'h3F45);
      probe_we(16'hA005, 8'hC3, we, wn);
      chk(we == 1'b1, "R8 enabled write p1", we, 1);
      look(16'hA005);
      chk(cpu_rdata == 8'hC3, "R7 read page1", cpu_rdata, 8'hC3);
      wr(16'h4000, 8'h00);
      look(16'hA005);
      chk(ram_addr == 14'h0005, "R7 ram_addr p0", ram_addr, 14'h0005);
      chk(cpu_rdata == 8'h5A, "R7 read page0", cpu_rdata, 8'h5A);

      // R9: missing pages
      for (int p = 2; p < 4; p++) begin
         wr(16'h4000, 8'(p | 8'hF0));
         look(16'hA005);
         chk(cpu_rdata == 8'hFF, "R9 missing read", cpu_rdata, 8'hFF);
         probe_we(16'hA005, 8'h77, we, wn);
         chk(we == 1'b0, "R9 missing write", we, 0);
      end
      wr(16'h4000, 8'h00);
      look(16'hA005);
      chk(cpu_rdata == 8'h5A, "R9 page0 intact", cpu_rdata, 8'h5A);

      // R8: disable blocks writes
      wr(16'h0000, 8'h0B);
      probe_we(16'hA005, 8'h99, we, wn);
      chk(we == 1'b0, "R8 disabled write", we, 0);
      look(16'hA005);
      chk(cpu_rdata == 8'h5A, "R8 data kept", cpu_rdata, 8'h5A);

      // R10: mode bit
      wr(16'h6000, 8'h01);
      look(16'h0000);
      chk(adv_mode == 1'b1, "R10 set", adv_mode, 1);
      wr(16'h7FFF, 8'hFE);
      look(16'h0000);
      chk(adv_mode == 1'b0, "R10 clear", adv_mode, 0);
      wr(16'h6ABC, 8'h03);
      look(16'h0000);
      chk(adv_mode == 1'b1, "R10 set again", adv_mode, 1);

      // R11: idle reads
      look(16'h8000); chk(cpu_rdata == 8'hFF, "R11 8000", cpu_rdata, 8'hFF);
      look(16'h9FFF); chk(cpu_rdata == 8'hFF, "R11 9FFF", cpu_rdata, 8'hFF);
      look(16'hC000); chk(cpu_rdata == 8'hFF, "R11 C000", cpu_rdata, 8'hFF);
      look(16'hFFFF); chk(cpu_rdata == 8'hFF, "R11 FFFF", cpu_rdata, 8'hFF);

      // R12: no-RAM reads
      wr(16'h0000, 8'h0A);
      look(16'hA010);
      chk(nr_rdata == 8'hFF, "R12 no-ram read", nr_rdata, 8'hFF);
      probe_we(16'hA010, 8'h33, we, wn);
      chk(wn == 1'b0, "R12 no-ram write", wn, 0);

      done = 1'b1;
      summary();
   end

endmodule